// File: doc/BRIEF.md
# Boot-Mode Program Store Gate

This block decides whether the processor runs from its built-in loader or from the program that the loader has placed in program memory. It also controls which writes reach that memory. After reset the block is in loader mode. In loader mode a write stream from the loader goes straight through to the program store, and instruction fetches are steered to the loader code.

The processor reports each taken branch with a strobe and the branch target. A taken branch to address zero ends loader mode for good. From the next cycle on, fetches are steered to the loaded program and the program store becomes read-only. Any later write request is accepted at the stream port and discarded, and a one-cycle error pulse is raised. Only a reset puts the block back into loader mode.

The write stream follows valid/ready rules. In loader mode, `ld_ready` follows the store's `pm_ready` in the same cycle. A request is taken on a cycle where valid and ready are both high, and the sender must hold address and data steady until then. Outside loader mode `ld_ready` stays high, so a dropped request never stalls the sender. The mode flag is held internally as a "loader finished" bit that is cleared at reset. Writes can reach the store only when the parameter `SHARED_STORE` is 1, its default.

Top module: `bootgate_top`

## Requirements
- R1: While reset is asserted and right after it is released, `in_loader` is 1, `fetch_sel` is 0 (loader code) and `ld_err` is 0.
- R2: A cycle with `br_taken`=1 and `br_target`=0 while `in_loader`=1 makes `in_loader` 0 after the next rising clock edge.
- R3: Once `in_loader` is 0 it stays 0 whatever the branch and write inputs do, until reset is asserted.
- R4: A taken branch to any nonzero target, or a zero target with `br_taken`=0, leaves `in_loader` unchanged.
- R5: While `in_loader`=1, `pm_we` equals `ld_valid`, `pm_addr`/`pm_data` equal `ld_addr`/`ld_data`, and `ld_ready` equals `pm_ready`, all in the same cycle.
- R6: While `in_loader`=0, `pm_we` is 0 and `ld_ready` is 1. A cycle with `ld_valid`=1 makes `ld_err` 1 for exactly the cycle after the next rising edge, and `ld_err` is 0 otherwise.
- R7: `fetch_sel` is 1 (loaded program) exactly when `in_loader` is 0, and changes in the same cycle as `in_loader`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_taken | input | 1 | Taken-branch strobe |
| br_target | input | ADDR_W | Branch target address |
| ld_valid | input | 1 | Loader write request valid |
| ld_ready | output | 1 | Loader write request ready |
| ld_addr | input | ADDR_W | Loader write address |
| ld_data | input | DATA_W | Loader write data |
| pm_we | output | 1 | Program store write enable |
| pm_ready | input | 1 | Program store can take a write |
| pm_addr | output | ADDR_W | Program store write address |
| pm_data | output | DATA_W | Program store write data |
| in_loader | output | 1 | 1 while in loader mode |
| fetch_sel | output | 1 | Fetch source: 0 loader code, 1 loaded program |
| ld_err | output | 1 | One-cycle pulse for a dropped write |

## Verification
The write path (`pm_we`, `pm_addr`, `pm_data`, `ld_ready`) is combinational. The bench therefore checks it in the same cycle, shortly after driving inputs on the falling edge. The mode flag, the fetch select and the error pulse are registered and due one rising edge after their cause. The bench compares them just after that edge with a model that it also advances only at that edge. Each of these results is thus checked at exactly one point in time, never earlier and never later.

// File: rtl/bootgate_pkg.sv
package bootgate_pkg;
  typedef enum logic {
    FETCH_LOADER  = 1'b0,
    FETCH_PROGRAM = 1'b1
  } fetch_src_e;
endpackage

// File: rtl/bootgate_mode.sv
// Mode register. It holds "loader finished", which is cleared at reset.
module bootgate_mode #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic              loading
);
  localparam logic [ADDR_W-1:0] ENTRY = '0;
  logic done_q;
  logic exit_hit;

  assign exit_hit = br_taken && (br_target == ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (exit_hit) done_q <= 1'b1;
  end

  assign loading = ~done_q;
endmodule

// File: rtl/bootgate_wgate.sv
// Write gate: passes loader writes through, or drops them.
module bootgate_wgate #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter bit SHARED_STORE = 1'b1
) (
  input  logic              loading,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              pm_we,
  input  logic              pm_ready,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [DATA_W-1:0] pm_data,
  output logic              drop
);
  logic open_path;

  generate
    if (SHARED_STORE) begin : g_shared
      assign open_path = loading;
    end else begin : g_split
      assign open_path = 1'b0;
    end
  endgenerate

  always_comb begin
    pm_addr  = ld_addr;
    pm_data  = ld_data;
    pm_we    = open_path & ld_valid;
    ld_ready = open_path ? pm_ready : 1'b1;
    drop     = ~open_path & ld_valid;
  end
endmodule

// File: rtl/bootgate_status.sv
// Registered error pulse and fetch source select.
module bootgate_status
  import bootgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loading,
  input  logic drop,
  output logic fetch_sel,
  output logic ld_err
);
  fetch_src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_err <= 1'b0;
    else        ld_err <= drop;
  end

  assign src       = loading ? FETCH_LOADER : FETCH_PROGRAM;
  assign fetch_sel = logic'(src);
endmodule

// File: rtl/bootgate_top.sv
module bootgate_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter bit SHARED_STORE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              pm_we,
  input  logic              pm_ready,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [DATA_W-1:0] pm_data,
  output logic              in_loader,
  output logic              fetch_sel,
  output logic              ld_err
);
  logic loading;
  logic drop;

  bootgate_mode #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken),
    .br_target(br_target), .loading(loading)
  );

  bootgate_wgate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SHARED_STORE(SHARED_STORE)) u_wgate (
    .loading(loading), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .pm_we(pm_we),
    .pm_ready(pm_ready), .pm_addr(pm_addr), .pm_data(pm_data),
    .drop(drop)
  );

  bootgate_status u_status (
    .clk(clk), .rst_n(rst_n), .loading(loading), .drop(drop),
    .fetch_sel(fetch_sel), .ld_err(ld_err)
  );

  assign in_loader = loading;
endmodule

// File: rtl/bootgate_checker.sv
module bootgate_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              pm_we,
  input logic              in_loader,
  input logic              fetch_sel,
  input logic              ld_err
);
  p_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loader && br_taken && br_target == '0) |=> !in_loader);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_loader |=> !in_loader);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loader && !(br_taken && br_target == '0)) |=> in_loader);

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> (in_loader && ld_valid));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_loader && ld_valid) |-> (!pm_we && ld_ready) ##1 ld_err);

  p_noerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loader || !ld_valid) |=> !ld_err);

  p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_sel == !in_loader);
endmodule

bind bootgate_top bootgate_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .pm_we(pm_we),
  .in_loader(in_loader), .fetch_sel(fetch_sel), .ld_err(ld_err)
);

// File: tb/bootgate_top_tb_top.sv
`timescale 1ns/1ps
module bootgate_top_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic pm_we;
  logic pm_ready = 1'b1;
  logic [AW-1:0] pm_addr;
  logic [DW-1:0] pm_data;
  logic in_loader, fetch_sel, ld_err;

  int n_tests = 0;
  int n_fail = 0;
  bit m_load = 1'b1;
  bit m_err = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bootgate_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_target(br_target),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_data(ld_data), .pm_we(pm_we), .pm_ready(pm_ready),
    .pm_addr(pm_addr), .pm_data(pm_data), .in_loader(in_loader),
    .fetch_sel(fetch_sel), .ld_err(ld_err)
  );

  function automatic bit exp_we(bit ld, bit v);
    return ld & v;
  endfunction
  function automatic bit exp_ready(bit ld, bit rdy);
    return ld ? rdy : 1'b1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    chk(req, "in_loader", in_loader, m_load);
    chk("R7", "fetch_sel", fetch_sel, !m_load);
    chk("R6", "ld_err", ld_err, m_err);
  endtask

  task automatic step(bit bt, logic [AW-1:0] tg, bit v,
                      logic [AW-1:0] a, logic [DW-1:0] d, bit rdy, string req);
    @(negedge clk);
    br_taken = bt; br_target = tg; ld_valid = v;
    ld_addr = a; ld_data = d; pm_ready = rdy;
    #1;
    chk(m_load ? "R5" : "R6", "pm_we", pm_we, exp_we(m_load, v));
    chk(m_load ? "R5" : "R6", "ld_ready", ld_ready, exp_ready(m_load, rdy));
    if (m_load) begin
      chk("R5", "pm_addr", pm_addr, a);
      chk("R5", "pm_data", pm_data, d);
    end
    @(posedge clk);
    m_err = v & !m_load;
    if (m_load && bt && tg == '0) m_load = 1'b0;
    #1;
    check_regs(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; br_taken = 1'b0; ld_valid = 1'b0;
    #1;
    chk("R1", "in_loader(rst)", in_loader, 1);
    chk("R1", "fetch_sel(rst)", fetch_sel, 0);
    chk("R1", "ld_err(rst)", ld_err, 0);
    @(negedge clk); rst_n = 1'b1;
    m_load = 1'b1; m_err = 1'b0;
    #1;
    check_regs("R1");
  endtask

  task automatic rand_phase(int cycles, int zero_pct);
    for (int i = 0; i < cycles; i++) begin
      bit bt = ($urandom % 4) == 0;
      logic [AW-1:0] tg = (($urandom % 100) < zero_pct) ? '0 : AW'($urandom % 4095 + 1);
      step(bt, tg, $urandom % 2, AW'($urandom), DW'($urandom), $urandom % 2,
           m_load ? "R4" : "R3");
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_b007));
    repeat (2) @(posedge clk);
    do_reset();
    // R4: nonzero target and untaken zero target keep loader mode
    step(1, 12'h001, 0, 0, 0, 1, "R4");
    step(1, 12'hFFF, 0, 0, 0, 1, "R4");
    step(0, 12'h000, 0, 0, 0, 1, "R4");
    // R5: writes pass, with and without back-pressure
    step(0, 0, 1, 12'h123, 16'hBEEF, 1, "R5");
    step(0, 0, 1, 12'h124, 16'hCAFE, 0, "R5");
    // R2: exit branch together with a write in the same cycle
    step(1, 12'h000, 1, 12'h200, 16'h1111, 1, "R2");
    // R6: dropped writes and error pulse; R3: second exit branch, no effect
    step(0, 0, 1, 12'h010, 16'h2222, 0, "R6");
    step(0, 0, 0, 0, 0, 1, "R6");
    step(1, 12'h000, 1, 12'h011, 16'h3333, 1, "R3");
    step(0, 0, 0, 0, 0, 1, "R3");
    rand_phase(300, 5);
    // R3: reset is the only way back into loader mode
    do_reset();
    rand_phase(300, 30);
    do_reset();
    rand_phase(200, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule